// File: doc/BRIEF.md
# Instruction-Boundary Event Dispatch Sequencer

This block sits beside an instruction pipeline and is consulted once per instruction boundary. It picks which pending event, if any, to service: a fault raised by the instruction that just ended, a single-step trap, a non-maskable interrupt, or a maskable interrupt offered by an interrupt controller. In real-addressing mode it then performs the whole interrupt entry by itself. It pushes the flags, code segment and instruction pointer onto the stack with one word write at a time, reads the new instruction pointer and code segment from the vector table, and presents the updated stack pointer, flags, code segment and instruction pointer together with a completion pulse.

When an entry sequence hits a memory fault, the block restarts the entry with the double-fault vector, using the code segment and pointer of the instruction start. A fault during that second entry raises a processor reset. When the protected-mode bit is set, no memory is touched; the chosen vector is handed to a separate protected-mode path as a one-cycle request.

The caller supplies the architectural state at each boundary and takes the results back after the completion pulse. The non-maskable enable, its auto-clear setting and the latched non-maskable request live inside the block.

Top module: `evt_dispatch`

## Requirements
- R1: After reset the block is idle: no memory request, no completion, protected-mode or reset pulse, and the non-maskable enable is set.
- R2: A fault flagged at a boundary is serviced with its own vector ahead of every other pending event.
- R3: Without a fault, a step trap (vector 1, taken when the trap flag was set at instruction start) beats a non-maskable interrupt (vector 2), which beats a maskable interrupt; the maskable one is taken only when flags bit 9 (interrupt enable) is 1.
- R4: A non-maskable interrupt is taken only while the enable is set, and taking it clears the enable; a request left pending is taken after the enable is set again.
- R5: With auto-clear set, taking a non-maskable interrupt also clears auto-clear and the latched request.
- R6: A maskable vector of 0xFF is treated as no interrupt: no memory access and no completion.
- R7: Real-mode entry writes flags to stack base + (SP-2), code segment to + (SP-4) and instruction pointer to + (SP-6), in that order, with the offsets wrapping at 16 bits; SP ends 6 lower, modulo 2^16.
- R8: The new instruction pointer is read from table base + vector*4 and then the new code segment from table base + vector*4 + 2.
- R9: On completion flags bits 9 (interrupt enable) and 8 (trap) are 0, and exactly one completion pulse is given.
- R10: A memory fault during an entry restarts it with vector 8, pushing the code segment and pointer of the instruction start.
- R11: A memory fault during the vector-8 entry gives a one-cycle processor-reset pulse and no completion.
- R12: With the protected-mode bit set, the block pulses a protected-mode request carrying the vector and performs no memory access.
- R13: Memory accesses go one at a time; a request and its address stay steady until acknowledged, and a plain entry takes exactly five accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bndValid | input | 1 | Instruction boundary strobe |
| faultIn | input | 1 | The ended instruction raised a fault |
| faultVec | input | 8 | Vector of that fault |
| startTf | input | 1 | Trap flag value at instruction start |
| nmiReqIn | input | 1 | Non-maskable request pulse (latched) |
| nmiEnSet | input | 1 | Set the non-maskable enable |
| autoClrSet | input | 1 | Set the auto-clear setting |
| intPending | input | 1 | Maskable interrupt pending |
| intVector | input | 8 | Vector from the interrupt controller |
| pmode | input | 1 | Protected-mode bit |
| curFlags | input | 16 | Flags at the boundary |
| curCs | input | 16 | Code segment at the boundary |
| curIp | input | 16 | Instruction pointer at the boundary |
| curSp | input | 16 | Stack pointer at the boundary |
| startCs | input | 16 | Code segment at instruction start |
| startIp | input | 16 | Instruction pointer at instruction start |
| ssBase | input | 20 | Stack segment base address |
| tblBase | input | 20 | Vector table base address |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 20 | Access address |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access acknowledge |
| memErr | input | 1 | Access faulted (with acknowledge) |
| memRdata | input | 16 | Read data (with acknowledge) |
| flagsOut | output | 16 | Resulting flags |
| csOut | output | 16 | Resulting code segment |
| ipOut | output | 16 | Resulting instruction pointer |
| spOut | output | 16 | Resulting stack pointer |
| done | output | 1 | Real-mode entry finished |
| pmReq | output | 1 | Hand vector to protected-mode path |
| pmVec | output | 8 | Vector being serviced |
| cpuReset | output | 1 | Processor reset request |

## Verification
The hardest state to reach is the reset escalation, which needs a second memory fault that lands inside the restarted vector-8 entry rather than the first one. The bench memory model counts accesses per scenario and faults on chosen access numbers, so one fault on the second write starts the double fault and another on the seventh access hits its table read. The non-maskable enable and auto-clear state are not visible at the ports, so they are probed by offering further boundaries and watching whether an entry starts.

// File: rtl/evt_dispatch_pkg.sv
package evt_dispatch_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] DF_VEC = 8'd8;
  localparam logic [VEC_W-1:0] STEP_VEC = 8'd1;
  localparam logic [VEC_W-1:0] NMI_VEC = 8'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP, ST_RD_IP, ST_RD_CS,
    ST_DONE, ST_PM, ST_RST
  } step_t;

  typedef struct packed {
    logic capture;
    logic ldVec;
    logic [VEC_W-1:0] vecVal;
    logic ldDf;
    logic ldIp;
    logic ldCs;
    logic commit;
    step_t step;
  } ctlStrobe_t;
endpackage

// File: rtl/evt_dispatch_dp.sv
module evt_dispatch_dp
  import evt_dispatch_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 20,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic [WORD_W-1:0] curFlags,
  input  logic [WORD_W-1:0] curCs,
  input  logic [WORD_W-1:0] curIp,
  input  logic [WORD_W-1:0] curSp,
  input  logic [WORD_W-1:0] startCs,
  input  logic [WORD_W-1:0] startIp,
  input  logic [ADDR_W-1:0] ssBase,
  input  logic [ADDR_W-1:0] tblBase,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] flagsOut,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] spOut,
  output logic [VEC_W-1:0]  vecOut
);
  localparam logic [WORD_W-1:0] WORD_BYTES = WORD_W'(WORD_W / 8);
  localparam logic [WORD_W-1:0] FRAME_BYTES = WORD_W'(3 * (WORD_W / 8));

  logic [WORD_W-1:0] flagsQ, csQ, ipQ, spQ, startCsQ, startIpQ;
  logic [VEC_W-1:0]  vecQ;
  logic [WORD_W-1:0] stackOff;
  logic [ADDR_W-1:0] entryAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= '0; csQ <= '0; ipQ <= '0; spQ <= '0;
      startCsQ <= '0; startIpQ <= '0; vecQ <= '0;
    end else begin
      if (strb.capture) begin
        flagsQ   <= curFlags;
        csQ      <= curCs;
        ipQ      <= curIp;
        spQ      <= curSp;
        startCsQ <= startCs;
        startIpQ <= startIp;
      end
      if (strb.ldVec) vecQ <= strb.vecVal;
      if (strb.ldDf) begin
        csQ  <= startCsQ;
        ipQ  <= startIpQ;
        vecQ <= DF_VEC;
      end
      if (strb.ldIp) ipQ <= memRdata;
      if (strb.ldCs) csQ <= memRdata;
      if (strb.commit) begin
        spQ <= spQ - FRAME_BYTES;
        flagsQ[IF_BIT] <= 1'b0;
        flagsQ[TF_BIT] <= 1'b0;
      end
    end
  end

  // Stack offsets wrap inside the word width; table entry is vector*4.
  always_comb begin
    stackOff  = spQ - WORD_BYTES;
    memWdata  = flagsQ;
    entryAddr = tblBase + ADDR_W'({vecQ, 2'b00});
    memAddr   = '0;
    case (strb.step)
      ST_PUSH_FL: begin stackOff = spQ - WORD_BYTES;      memWdata = flagsQ; end
      ST_PUSH_CS: begin stackOff = spQ - 2 * WORD_BYTES;  memWdata = csQ;    end
      ST_PUSH_IP: begin stackOff = spQ - FRAME_BYTES;     memWdata = ipQ;    end
      default: ;
    endcase
    case (strb.step)
      ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: memAddr = ssBase + ADDR_W'(stackOff);
      ST_RD_IP: memAddr = entryAddr;
      ST_RD_CS: memAddr = entryAddr + ADDR_W'(WORD_BYTES);
      default:  memAddr = '0;
    endcase
  end

  assign flagsOut = flagsQ;
  assign csOut    = csQ;
  assign ipOut    = ipQ;
  assign spOut    = spQ;
  assign vecOut   = vecQ;
endmodule

// File: rtl/evt_dispatch_ctl.sv
module evt_dispatch_ctl
  import evt_dispatch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bndValid,
  input  logic             faultIn,
  input  logic [VEC_W-1:0] faultVec,
  input  logic             startTf,
  input  logic             nmiReqIn,
  input  logic             nmiEnSet,
  input  logic             autoClrSet,
  input  logic             intPending,
  input  logic [VEC_W-1:0] intVector,
  input  logic             ifFlag,
  input  logic             pmode,
  input  logic             memAck,
  input  logic             memErr,
  output ctlStrobe_t       strb,
  output logic             memReq,
  output logic             memWe,
  output logic             done,
  output logic             pmReq,
  output logic             cpuReset
);
  step_t stateQ, nextState;
  logic dfQ, setDf;
  logic nmiPendQ, nmiEnQ, autoClrQ;
  logic evtValid, takeNmi;
  logic [VEC_W-1:0] evtVec;
  logic atBoundary;

  assign atBoundary = (stateQ == ST_IDLE) && bndValid;

  // Fixed order: fault, step trap, non-maskable, maskable.
  always_comb begin
    evtValid = 1'b0;
    evtVec   = '0;
    takeNmi  = 1'b0;
    if (faultIn) begin
      evtValid = 1'b1; evtVec = faultVec;
    end else if (startTf) begin
      evtValid = 1'b1; evtVec = STEP_VEC;
    end else if (nmiPendQ && nmiEnQ) begin
      evtValid = 1'b1; evtVec = NMI_VEC; takeNmi = 1'b1;
    end else if (ifFlag && intPending && (intVector != '1)) begin
      evtValid = 1'b1; evtVec = intVector;
    end
  end

  always_comb begin
    nextState = stateQ;
    strb      = '0;
    strb.step = stateQ;
    memReq    = 1'b0;
    memWe     = 1'b0;
    done      = 1'b0;
    pmReq     = 1'b0;
    cpuReset  = 1'b0;
    setDf     = 1'b0;
    case (stateQ)
      ST_IDLE: if (bndValid) begin
        strb.capture = 1'b1;
        if (evtValid) begin
          strb.ldVec  = 1'b1;
          strb.vecVal = evtVec;
          nextState   = pmode ? ST_PM : ST_PUSH_FL;
        end
      end
      ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP, ST_RD_IP, ST_RD_CS: begin
        memReq = 1'b1;
        memWe  = (stateQ == ST_PUSH_FL) || (stateQ == ST_PUSH_CS) || (stateQ == ST_PUSH_IP);
        if (memAck) begin
          if (memErr) begin
            if (dfQ) nextState = ST_RST;
            else begin
              strb.ldDf = 1'b1;
              setDf     = 1'b1;
              nextState = ST_PUSH_FL;
            end
          end else begin
            case (stateQ)
              ST_PUSH_FL: nextState = ST_PUSH_CS;
              ST_PUSH_CS: nextState = ST_PUSH_IP;
              ST_PUSH_IP: nextState = ST_RD_IP;
              ST_RD_IP: begin strb.ldIp = 1'b1; nextState = ST_RD_CS; end
              default: begin
                strb.ldCs   = 1'b1;
                strb.commit = 1'b1;
                nextState   = ST_DONE;
              end
            endcase
          end
        end
      end
      ST_DONE: begin done = 1'b1;     nextState = ST_IDLE; end
      ST_PM:   begin pmReq = 1'b1;    nextState = ST_IDLE; end
      ST_RST:  begin cpuReset = 1'b1; nextState = ST_IDLE; end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      dfQ      <= 1'b0;
      nmiPendQ <= 1'b0;
      nmiEnQ   <= 1'b1;
      autoClrQ <= 1'b0;
    end else begin
      stateQ <= nextState;
      if (atBoundary) dfQ <= 1'b0;
      if (setDf) dfQ <= 1'b1;
      if (nmiReqIn) nmiPendQ <= 1'b1;
      if (nmiEnSet) nmiEnQ <= 1'b1;
      if (autoClrSet) autoClrQ <= 1'b1;
      if (atBoundary && takeNmi) begin
        nmiEnQ <= 1'b0;
        if (autoClrQ) begin
          autoClrQ <= 1'b0;
          nmiPendQ <= 1'b0;
        end
      end
    end
  end

  // R13: an outstanding request is never withdrawn before its acknowledge.
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq);
  // R12: the protected-mode hand-off is never preceded by a memory access.
  assert_pm_nomem_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pmReq |-> !$past(memReq));
endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
  import evt_dispatch_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 20,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bndValid,
  input  logic              faultIn,
  input  logic [VEC_W-1:0]  faultVec,
  input  logic              startTf,
  input  logic              nmiReqIn,
  input  logic              nmiEnSet,
  input  logic              autoClrSet,
  input  logic              intPending,
  input  logic [VEC_W-1:0]  intVector,
  input  logic              pmode,
  input  logic [WORD_W-1:0] curFlags,
  input  logic [WORD_W-1:0] curCs,
  input  logic [WORD_W-1:0] curIp,
  input  logic [WORD_W-1:0] curSp,
  input  logic [WORD_W-1:0] startCs,
  input  logic [WORD_W-1:0] startIp,
  input  logic [ADDR_W-1:0] ssBase,
  input  logic [ADDR_W-1:0] tblBase,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] flagsOut,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] spOut,
  output logic              done,
  output logic              pmReq,
  output logic [VEC_W-1:0]  pmVec,
  output logic              cpuReset
);
  ctlStrobe_t strb;

  evt_dispatch_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .bndValid(bndValid), .faultIn(faultIn),
    .faultVec(faultVec), .startTf(startTf), .nmiReqIn(nmiReqIn),
    .nmiEnSet(nmiEnSet), .autoClrSet(autoClrSet), .intPending(intPending),
    .intVector(intVector), .ifFlag(curFlags[IF_BIT]), .pmode(pmode),
    .memAck(memAck), .memErr(memErr), .strb(strb), .memReq(memReq),
    .memWe(memWe), .done(done), .pmReq(pmReq), .cpuReset(cpuReset)
  );

  evt_dispatch_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .curFlags(curFlags), .curCs(curCs),
    .curIp(curIp), .curSp(curSp), .startCs(startCs), .startIp(startIp),
    .ssBase(ssBase), .tblBase(tblBase), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .flagsOut(flagsOut), .csOut(csOut), .ipOut(ipOut),
    .spOut(spOut), .vecOut(pmVec)
  );

  // R13: address and direction stay put while a request waits.
  assert_addr_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWe));
  // R9: completion leaves interrupt-enable and trap cleared.
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flagsOut[IF_BIT] && !flagsOut[TF_BIT]);
  // R9: at most one outcome pulse per cycle.
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, pmReq, cpuReset}));
  // R7: stack pointer drops by one frame exactly at completion.
  assert_sp_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spOut == $past(spOut) - WORD_W'(3 * (WORD_W / 8)));
  // R11: a reset request only follows the double-fault entry.
  assert_reset_after_df_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpuReset |-> pmVec == DF_VEC);
endmodule

// File: tb/evt_dispatch_tb.sv
module evt_dispatch_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bndValid = 0, faultIn = 0, startTf = 0, nmiReqIn = 0, nmiEnSet = 0;
  logic autoClrSet = 0, intPending = 0, pmode = 0;
  logic [7:0] faultVec = 0, intVector = 0;
  logic [15:0] curFlags = 0, curCs = 0, curIp = 0, curSp = 0, startCs = 0, startIp = 0;
  logic [19:0] ssBase = 20'h20000, tblBase = 20'h00400;
  logic memReq, memWe, memAck, memErr, done, pmReq, cpuReset;
  logic [19:0] memAddr;
  logic [15:0] memWdata, memRdata, flagsOut, csOut, ipOut, spOut;
  logic [7:0] pmVec;

  int checks = 0, errors = 0;
  logic [15:0] mem [int];
  logic [19:0] logAddr [16];
  logic [15:0] logData [16];
  int logN = 0, accN = 0;
  logic [31:0] errMask = 0;
  logic sawReq = 0;

  always #4 clk = ~clk;

  evt_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .bndValid(bndValid), .faultIn(faultIn), .faultVec(faultVec),
    .startTf(startTf), .nmiReqIn(nmiReqIn), .nmiEnSet(nmiEnSet), .autoClrSet(autoClrSet),
    .intPending(intPending), .intVector(intVector), .pmode(pmode), .curFlags(curFlags),
    .curCs(curCs), .curIp(curIp), .curSp(curSp), .startCs(startCs), .startIp(startIp),
    .ssBase(ssBase), .tblBase(tblBase), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .flagsOut(flagsOut), .csOut(csOut), .ipOut(ipOut), .spOut(spOut), .done(done),
    .pmReq(pmReq), .pmVec(pmVec), .cpuReset(cpuReset)
  );

  // Memory model: acknowledge one cycle after a request, optional fault by access number.
  always @(posedge clk) begin
    if (!rst_n) begin
      memAck <= 0; memErr <= 0; memRdata <= 0;
    end else if (memReq && !memAck) begin
      sawReq = 1;
      accN = accN + 1;
      memAck <= 1;
      memErr <= errMask[accN];
      memRdata <= mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 16'h0;
      if (memWe && !errMask[accN]) begin
        mem[int'(memAddr)] = memWdata;
        if (logN < 16) begin logAddr[logN] = memAddr; logData[logN] = memWdata; end
        logN = logN + 1;
      end
    end else begin
      memAck <= 0; memErr <= 0;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setVec(logic [7:0] v, logic [15:0] ip, logic [15:0] cs);
    mem[int'(tblBase) + int'(v) * 4] = ip;
    mem[int'(tblBase) + int'(v) * 4 + 2] = cs;
  endtask

  task automatic setup(logic [15:0] fl, logic [15:0] sp);
    @(negedge clk);
    curFlags = fl; curCs = 16'h1234; curIp = 16'h0100; curSp = sp;
    startCs = 16'h1230; startIp = 16'h00F0;
    faultIn = 0; startTf = 0; intPending = 0; pmode = 0;
    logN = 0; accN = 0; errMask = 0; sawReq = 0;
  endtask

  task automatic boundary();
    @(negedge clk); bndValid = 1;
    @(negedge clk); bndValid = 0;
  endtask

  task automatic pulseNmi(logic en, logic ac, logic req);
    @(negedge clk); nmiEnSet = en; autoClrSet = ac; nmiReqIn = req;
    @(negedge clk); nmiEnSet = 0; autoClrSet = 0; nmiReqIn = 0;
  endtask

  // 1 = done, 2 = protected-mode request, 3 = reset, 0 = nothing within the window
  task automatic waitEvt(output int kind);
    kind = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin kind = 1; break; end
      if (pmReq) begin kind = 2; break; end
      if (cpuReset) begin kind = 3; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1", "memReq", memReq, 0);
    check("R1", "done", done, 0);
    check("R1", "pmReq/cpuReset", {pmReq, cpuReset}, 0);
  endtask

  task automatic t_plainEntry();
    int k;
    setVec(8'h21, 16'h5678, 16'h9ABC);
    setup(16'h0302, 16'h0100);
    intPending = 1; intVector = 8'h21;
    boundary(); intPending = 0; waitEvt(k);
    check("R9", "completion", k, 1);
    check("R7", "write count", logN, 3);
    check("R7", "flags addr", logAddr[0], 20'h200FE);
    check("R7", "flags data", logData[0], 16'h0302);
    check("R7", "cs addr", logAddr[1], 20'h200FC);
    check("R7", "cs data", logData[1], 16'h1234);
    check("R7", "ip addr", logAddr[2], 20'h200FA);
    check("R7", "ip data", logData[2], 16'h0100);
    check("R7", "sp", spOut, 16'h00FA);
    check("R8", "new ip", ipOut, 16'h5678);
    check("R8", "new cs", csOut, 16'h9ABC);
    check("R9", "flags IF/TF cleared", flagsOut, 16'h0002);
    check("R13", "access count", accN, 5);
    @(negedge clk);
    check("R9", "single pulse", done, 0);
  endtask

  task automatic t_wrap();
    int k;
    setup(16'h0202, 16'h0002);
    intPending = 1; intVector = 8'h21;
    boundary(); intPending = 0; waitEvt(k);
    check("R7", "wrap completion", k, 1);
    check("R7", "wrap flags addr", logAddr[0], 20'h20000);
    check("R7", "wrap cs addr", logAddr[1], 20'h2FFFE);
    check("R7", "wrap ip addr", logAddr[2], 20'h2FFFC);
    check("R7", "wrap sp", spOut, 16'hFFFC);
  endtask

  task automatic t_priority();
    int k;
    setVec(8'h01, 16'h1111, 16'hA001);
    setVec(8'h02, 16'h2222, 16'hA002);
    pulseNmi(0, 0, 1);
    setup(16'h0202, 16'h0200);
    startTf = 1; intPending = 1; intVector = 8'h21;
    boundary(); waitEvt(k);
    check("R3", "step trap wins", {k[7:0], ipOut}, {8'd1, 16'h1111});
    setup(16'h0202, 16'h0200);
    intPending = 1; intVector = 8'h21;
    boundary(); waitEvt(k);
    check("R3", "nmi beats maskable", {k[7:0], ipOut}, {8'd1, 16'h2222});
    setup(16'h0202, 16'h0200);
    intPending = 1; intVector = 8'h21;
    boundary(); waitEvt(k);
    check("R4", "nmi blocked after taking, maskable taken", {k[7:0], ipOut}, {8'd1, 16'h5678});
    setup(16'h0002, 16'h0200);
    intPending = 1; intVector = 8'h21;
    boundary(); waitEvt(k);
    check("R3", "IF=0 blocks maskable", {k[7:0], 7'd0, sawReq}, 0);
  endtask

  task automatic t_nmiGate();
    int k;
    setup(16'h0002, 16'h0200);
    pulseNmi(1, 0, 0);
    boundary(); waitEvt(k);
    check("R4", "pending nmi taken after enable set", {k[7:0], ipOut}, {8'd1, 16'h2222});
    setup(16'h0002, 16'h0200);
    pulseNmi(1, 1, 0);
    boundary(); waitEvt(k);
    check("R5", "nmi taken with auto-clear", {k[7:0], ipOut}, {8'd1, 16'h2222});
    setup(16'h0002, 16'h0200);
    pulseNmi(1, 0, 0);
    boundary(); waitEvt(k);
    check("R5", "request cleared by auto-clear", {k[7:0], 7'd0, sawReq}, 0);
  endtask

  task automatic t_ff();
    int k;
    setup(16'h0202, 16'h0200);
    intPending = 1; intVector = 8'hFF;
    boundary(); waitEvt(k);
    check("R6", "vector FF ignored", {k[7:0], 7'd0, sawReq}, 0);
    check("R6", "ip unchanged", ipOut, 16'h0100);
  endtask

  task automatic t_fault();
    int k;
    setVec(8'h0D, 16'h0D0D, 16'hB00D);
    setup(16'h0202, 16'h0200);
    faultIn = 1; faultVec = 8'h0D; startTf = 1; intPending = 1; intVector = 8'h21;
    pulseNmi(1, 0, 1);
    boundary(); faultIn = 0; waitEvt(k);
    check("R2", "fault first", {k[7:0], ipOut, csOut}, {8'd1, 16'h0D0D, 16'hB00D});
    // leave the NMI pending consumed with auto-clear for later scenarios
    setup(16'h0002, 16'h0200);
    pulseNmi(1, 1, 0);
    boundary(); waitEvt(k);
  endtask

  task automatic t_doubleFault();
    int k;
    setVec(8'h08, 16'h0808, 16'hD008);
    setup(16'h0202, 16'h0200);
    faultIn = 1; faultVec = 8'h0D;
    errMask = 32'h4;
    boundary(); faultIn = 0; waitEvt(k);
    check("R10", "df completion", k, 1);
    check("R10", "df pushes", logN, 4);
    check("R10", "df start cs pushed", logData[2], 16'h1230);
    check("R10", "df start ip pushed", logData[3], 16'h00F0);
    check("R10", "df vector ip/cs", {ipOut, csOut}, {16'h0808, 16'hD008});
  endtask

  task automatic t_triple();
    int k;
    setup(16'h0202, 16'h0200);
    faultIn = 1; faultVec = 8'h0D;
    errMask = 32'h84;
    boundary(); faultIn = 0; waitEvt(k);
    check("R11", "reset pulse", k, 3);
    @(negedge clk);
    check("R11", "reset is one cycle", {cpuReset, done}, 0);
  endtask

  task automatic t_pmode();
    int k;
    setup(16'h0202, 16'h0200);
    pmode = 1; intPending = 1; intVector = 8'h30;
    boundary(); waitEvt(k);
    check("R12", "pm request", {k[7:0], pmVec}, {8'd2, 8'h30});
    check("R12", "no memory in pm", sawReq, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plainEntry();
    t_wrap();
    t_priority();
    t_nmiGate();
    t_ff();
    t_fault();
    t_doubleFault();
    t_triple();
    t_pmode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule